// File: doc/BRIEF.md
# I2S Master Bit-Clock and Word-Select Generator

This block turns a fast, fixed reference clock (160 MHz in the target system) into the timing signals an I2S master drives: a bit clock and a word-select line. Two programmable dividers are chained. A prescaler divides the reference into an intermediate audio tick. A bit divider then divides that tick into bit-clock periods. Word select changes once per channel slot, and a slot lasts 16 bit clocks plus a 4-bit programmable extension, so a slot is 16 to 31 bits long. Two single-cycle strobes mark the start of every bit period and the start of every frame.

Everything runs in the reference-clock domain. The bit clock is produced as a registered level, not as a derived clock net, and the strobes are meant to be used as clock enables by a serializer downstream. Configuration is taken when the block is enabled and again at each frame boundary, so a rate change never produces a truncated slot. The control sequencer has two states. **IDLE** holds every output low and the counters at zero. **RUN** lets the counters advance. The transition **START** (IDLE to RUN) is taken when `en` is sampled high, and it also loads the configuration. The transition **STOP** (RUN to IDLE) is taken when `en` is sampled low, and it clears all counters. **RELOAD** is a self-transition of RUN at the frame wrap, and it loads the configuration again.

Top module: `i2s_clkgen`

## Requirements
- R1: While `rst_n` is low, and while the block is idle, `bclk_o`, `ws_o`, `bit_stb_o` and `frame_stb_o` are all 0.
- R2: `en` is sampled high at a clock edge while the block is idle. In the cycle after that edge, `bit_stb_o`=1, `frame_stb_o`=1, `bclk_o`=1 and `ws_o`=0.
- R3: The bit clock period is P·B reference cycles, where P is the effective prescale divisor and B is the effective bit divisor. `bclk_o` is high for P·ceil(B/2) of those cycles and low for the rest, so with an odd B the high phase is one intermediate tick longer than the low phase.
- R4: `cfg_prescale` (6 bits) takes effect unchanged from 5 to 63. Any value below 5 is treated as 5.
- R5: `cfg_bitdiv` (6 bits) takes effect unchanged from 2 to 63. Any value below 2 is treated as 2.
- R6: A slot lasts L = 16 + `cfg_slot_ext` bit periods. `ws_o` is 0 in the first slot of a frame and 1 in the second slot. `ws_o` changes only in a cycle where `bit_stb_o` is 1.
- R7: `bit_stb_o` is high for exactly one reference cycle at the start of each bit period, which is the first cycle in which `bclk_o` is high. A frame contains 2·L such strobes.
- R8: `frame_stb_o` is high for exactly one cycle, in the cycle where the first bit of the `ws_o`=0 slot begins. It is never high without `bit_stb_o`.
- R9: The configuration inputs are sampled only at START and at the frame wrap. A change made in the middle of a frame leaves the rest of that frame unaffected.
- R10: `en` is sampled low while the block is running. In the next cycle all outputs are 0 and the counters are cleared. A later START restarts the block as in R2.
- R11: Consecutive `frame_stb_o` pulses are 2·L·B·P reference cycles apart. For example, P=13, B=4 and extension 15 give 3224 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the block idle |
| cfg_prescale | input | 6 | Prescale divisor, clamped to at least 5 |
| cfg_bitdiv | input | 6 | Bit-clock divisor, clamped to at least 2 |
| cfg_slot_ext | input | 4 | Slot length minus 16 |
| bclk_o | output | 1 | Bit clock level |
| ws_o | output | 1 | Word select (0 = first channel) |
| bit_stb_o | output | 1 | One-cycle pulse at the start of each bit period |
| frame_stb_o | output | 1 | One-cycle pulse at the start of each frame |

## Verification
The embedded properties take for granted that the configuration inputs are stable around the clock edge at which they are loaded. They also assume that `en` is a synchronous level, and that reset is asserted before the first edge at which the counters are compared against the active divisors. The stimulus changes configuration and `en` only on falling clock edges. Configuration changes are made both in the middle of a frame and while the block is idle, to exercise the R9 sampling points. The stimulus covers sub-minimum divisor values, even and odd bit divisors, the shortest and longest slot extensions, and a stop and restart in the middle of a frame.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

    // Control sequencer states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // Clamp a divisor field to a floor value
    function automatic logic [7:0] clamp_floor(input logic [7:0] v, input logic [7:0] floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

endpackage

// File: rtl/i2s_cfg_latch.sv
module i2s_cfg_latch #(
    parameter int PRE_W     = 6,
    parameter int BIT_W     = 6,
    parameter int EXT_W     = 4,
    parameter int PRE_MIN   = 5,
    parameter int BIT_MIN   = 2,
    parameter int SLOT_BASE = 16,
    parameter int SLOT_W    = $clog2(SLOT_BASE + (1 << EXT_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PRE_W-1:0]  raw_pre,
    input  logic [BIT_W-1:0]  raw_bit,
    input  logic [EXT_W-1:0]  raw_ext,
    output logic [PRE_W-1:0]  act_pre,
    output logic [BIT_W-1:0]  act_bit,
    output logic [SLOT_W-1:0] act_slot_len
);
    import i2s_clkgen_pkg::*;

    localparam logic [PRE_W-1:0] PRE_FLOOR = PRE_W'(PRE_MIN);
    localparam logic [BIT_W-1:0] BIT_FLOOR = BIT_W'(BIT_MIN);

    logic [PRE_W-1:0]  pre_c;
    logic [BIT_W-1:0]  bit_c;
    logic [SLOT_W-1:0] len_c;

    always_comb begin
        pre_c = PRE_W'(clamp_floor(8'(raw_pre), 8'(PRE_FLOOR)));
        bit_c = BIT_W'(clamp_floor(8'(raw_bit), 8'(BIT_FLOOR)));
        len_c = SLOT_W'(SLOT_BASE) + SLOT_W'(raw_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pre      <= PRE_FLOOR;
            act_bit      <= BIT_FLOOR;
            act_slot_len <= SLOT_W'(SLOT_BASE);
        end else if (load) begin
            act_pre      <= pre_c;
            act_bit      <= bit_c;
            act_slot_len <= len_c;
        end
    end

    // R9: active settings move only when a load was requested
    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_pre) && $stable(act_bit) && $stable(act_slot_len)));

    // R4: effective prescale never below its floor
    a_r4_pre_floor: assert property (@(posedge clk) disable iff (!rst_n)
        act_pre >= PRE_FLOOR);

    // R5: effective bit divisor never below its floor
    a_r5_bit_floor: assert property (@(posedge clk) disable iff (!rst_n)
        act_bit >= BIT_FLOOR);

endmodule

// File: rtl/i2s_div_stage.sv
module i2s_div_stage #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] div,
    output logic         wrap,
    output logic         at_zero,
    output logic         hi_phase
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W:0]   half_hi;

    always_comb begin
        wrap     = adv && (cnt_q == (div - ONE));
        at_zero  = (cnt_q == '0);
        half_hi  = ({1'b0, div} + (W+1)'(1)) >> 1;
        hi_phase = ({1'b0, cnt_q} < half_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + ONE;
        end
    end

    // R3: the count stays inside the active divisor
    a_r3_cnt_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < div);

    // R7: after a wrap the count restarts at zero
    a_r7_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/i2s_slot_seq.sv
module i2s_slot_seq #(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SLOT_W-1:0] slot_len,
    input  logic              bit_wrap,
    input  logic              pre_zero,
    input  logic              bit_zero,
    input  logic              bit_hi,
    output logic              cnt_clr,
    output logic              cfg_load,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              bit_stb_o,
    output logic              frame_stb_o
);
    import i2s_clkgen_pkg::*;

    localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              ws_q;
    logic              last_bit;
    logic              frame_wrap;
    logic              running;

    always_comb begin
        running    = (state_q == ST_RUN);
        last_bit   = (slot_q == (slot_len - ONE));
        frame_wrap = bit_wrap && last_bit && ws_q;
    end

    // next-state: START, STOP, RELOAD (self loop)
    always_comb begin
        state_d  = state_q;
        cfg_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d  = ST_RUN;
                    cfg_load = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (frame_wrap) begin
                    cfg_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and slot position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            ws_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!(running && en)) begin
                slot_q <= '0;
                ws_q   <= 1'b0;
            end else if (bit_wrap) begin
                if (last_bit) begin
                    slot_q <= '0;
                    ws_q   <= ~ws_q;
                end else begin
                    slot_q <= slot_q + ONE;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cnt_clr     = 1'b1;
        bclk_o      = 1'b0;
        ws_o        = 1'b0;
        bit_stb_o   = 1'b0;
        frame_stb_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr = 1'b1;
            end
            ST_RUN: begin
                cnt_clr     = !en;
                bclk_o      = bit_hi;
                ws_o        = ws_q;
                bit_stb_o   = pre_zero && bit_zero;
                frame_stb_o = pre_zero && bit_zero && (slot_q == '0) && !ws_q;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

    // R8: a frame strobe always coincides with a bit strobe
    a_r8_frame_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_o |-> bit_stb_o);

    // R6: word select moves only at the start of a bit period
    a_r6_ws_moves_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(state_q == ST_RUN) && !$stable(ws_q)) |-> bit_stb_o);

    // R6: slot position stays inside the slot length
    a_r6_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q < slot_len);

    // R1: idle keeps every output low
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !(bclk_o || ws_o || bit_stb_o || frame_stb_o));

    // R10: dropping enable returns to idle with a cleared slot position
    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !en) |=> (state_q == ST_IDLE && slot_q == '0 && !ws_q));

    // R2: start enters run on the following edge
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && en) |=> (running && frame_stb_o));

endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
    parameter int PRE_W     = 6,
    parameter int BIT_W     = 6,
    parameter int EXT_W     = 4,
    parameter int PRE_MIN   = 5,
    parameter int BIT_MIN   = 2,
    parameter int SLOT_BASE = 16
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic [BIT_W-1:0] cfg_bitdiv,
    input  logic [EXT_W-1:0] cfg_slot_ext,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             bit_stb_o,
    output logic             frame_stb_o
);
    localparam int SLOT_W = $clog2(SLOT_BASE + (1 << EXT_W));

    logic [PRE_W-1:0]  act_pre;
    logic [BIT_W-1:0]  act_bit;
    logic [SLOT_W-1:0] act_len;
    logic              cnt_clr;
    logic              cfg_load;
    logic              pre_wrap, pre_zero, pre_hi_unused;
    logic              bit_wrap, bit_zero, bit_hi;

    i2s_cfg_latch #(
        .PRE_W(PRE_W), .BIT_W(BIT_W), .EXT_W(EXT_W),
        .PRE_MIN(PRE_MIN), .BIT_MIN(BIT_MIN),
        .SLOT_BASE(SLOT_BASE), .SLOT_W(SLOT_W)
    ) u_cfg (
        .clk(clk_ref), .rst_n(rst_n), .load(cfg_load),
        .raw_pre(cfg_prescale), .raw_bit(cfg_bitdiv), .raw_ext(cfg_slot_ext),
        .act_pre(act_pre), .act_bit(act_bit), .act_slot_len(act_len)
    );

    // prescaler: advances every reference cycle
    i2s_div_stage #(.W(PRE_W)) u_pre (
        .clk(clk_ref), .rst_n(rst_n), .clr(cnt_clr), .adv(1'b1),
        .div(act_pre), .wrap(pre_wrap), .at_zero(pre_zero), .hi_phase(pre_hi_unused)
    );

    // bit divider: advances on each prescaler wrap
    i2s_div_stage #(.W(BIT_W)) u_bit (
        .clk(clk_ref), .rst_n(rst_n), .clr(cnt_clr), .adv(pre_wrap),
        .div(act_bit), .wrap(bit_wrap), .at_zero(bit_zero), .hi_phase(bit_hi)
    );

    i2s_slot_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk(clk_ref), .rst_n(rst_n), .en(en), .slot_len(act_len),
        .bit_wrap(bit_wrap), .pre_zero(pre_zero), .bit_zero(bit_zero), .bit_hi(bit_hi),
        .cnt_clr(cnt_clr), .cfg_load(cfg_load),
        .bclk_o(bclk_o), .ws_o(ws_o), .bit_stb_o(bit_stb_o), .frame_stb_o(frame_stb_o)
    );

    // R11: a frame start is also the first cycle of a prescale period
    a_r11_frame_aligned: assert property (@(posedge clk_ref) disable iff (!rst_n)
        frame_stb_o |-> (pre_zero && bit_zero));

endmodule

// File: tb/i2s_clkgen_tb_top.sv
module i2s_clkgen_tb_top;
    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic       en      = 1'b0;
    logic [5:0] cfg_prescale = 6'd5;
    logic [5:0] cfg_bitdiv   = 6'd2;
    logic [3:0] cfg_slot_ext = 4'd0;
    logic       bclk_o, ws_o, bit_stb_o, frame_stb_o;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #2.5 clk_ref = ~clk_ref;

    i2s_clkgen dut_i (
        .clk_ref(clk_ref), .rst_n(rst_n), .en(en),
        .cfg_prescale(cfg_prescale), .cfg_bitdiv(cfg_bitdiv), .cfg_slot_ext(cfg_slot_ext),
        .bclk_o(bclk_o), .ws_o(ws_o), .bit_stb_o(bit_stb_o), .frame_stb_o(frame_stb_o)
    );

    // behavioural reference
    int  m_pre = 5, m_bit = 2, m_len = 16;
    int  m_pc = 0, m_bc = 0, m_sb = 0;
    bit  m_ws = 0, m_run = 0;

    function automatic int fl(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

    task automatic m_load();
        m_pre = fl(int'(cfg_prescale), 5);
        m_bit = fl(int'(cfg_bitdiv), 2);
        m_len = 16 + int'(cfg_slot_ext);
    endtask

    always @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 5; m_bit = 2; m_len = 16;
            m_pc = 0; m_bc = 0; m_sb = 0; m_ws = 0; m_run = 0;
        end else if (!m_run) begin
            if (en) begin
                m_run = 1; m_load();
                m_pc = 0; m_bc = 0; m_sb = 0; m_ws = 0;
            end
        end else if (!en) begin
            m_run = 0; m_pc = 0; m_bc = 0; m_sb = 0; m_ws = 0;
        end else begin
            bit pw, bw, fw;
            pw = (m_pc == m_pre - 1);
            bw = pw && (m_bc == m_bit - 1);
            fw = bw && (m_sb == m_len - 1) && m_ws;
            m_pc = pw ? 0 : m_pc + 1;
            if (pw) m_bc = bw ? 0 : m_bc + 1;
            if (bw) begin
                if (m_sb == m_len - 1) begin m_sb = 0; m_ws = !m_ws; end
                else m_sb = m_sb + 1;
            end
            if (fw) m_load();
        end
    end

    // per-cycle comparison
    always @(negedge clk_ref) begin
        if (!done) begin
            bit e_bclk, e_ws, e_bit, e_frm;
            e_bclk = m_run && (m_bc < (m_bit + 1) / 2);
            e_ws   = m_run && m_ws;
            e_bit  = m_run && m_pc == 0 && m_bc == 0;
            e_frm  = e_bit && m_sb == 0 && !m_ws;
            compared++;
            if (bclk_o !== e_bclk) begin mismatched++; $display("FAIL R3 bclk at %0t: actual %b expected %b", $time, bclk_o, e_bclk); end
            if (ws_o !== e_ws) begin mismatched++; $display("FAIL R6 ws at %0t: actual %b expected %b", $time, ws_o, e_ws); end
            if (bit_stb_o !== e_bit) begin mismatched++; $display("FAIL R7 bit strobe at %0t: actual %b expected %b", $time, bit_stb_o, e_bit); end
            if (frame_stb_o !== e_frm) begin mismatched++; $display("FAIL R8 frame strobe at %0t: actual %b expected %b", $time, frame_stb_o, e_frm); end
        end
    end

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(int p, int b, int x);
        cfg_prescale = 6'(p); cfg_bitdiv = 6'(b); cfg_slot_ext = 4'(x);
    endtask

    task automatic wait_frame();
        do @(negedge clk_ref); while (!frame_stb_o);
    endtask

    // from a frame strobe, count cycles and bit strobes to the next one
    task automatic measure_frame(string tag, int exp_cycles, int exp_bits);
        int n = 0, bits = 0;
        wait_frame();
        do begin
            @(negedge clk_ref); n++;
            if (bit_stb_o) bits++;
        end while (!frame_stb_o);
        check({tag, " frame period"}, n, exp_cycles);
        check("R7 bit strobes per frame", bits, exp_bits);
    endtask

    task automatic measure_bit(string tag, int exp_hi, int exp_period);
        int hi = 0, n = 0;
        do @(negedge clk_ref); while (!bit_stb_o);
        do begin
            if (bclk_o) hi++;
            @(negedge clk_ref); n++;
        end while (!bit_stb_o);
        check({tag, " high phase"}, hi, exp_hi);
        check({tag, " bit period"}, n, exp_period);
    endtask

    function automatic int outs();
        return int'({bclk_o, ws_o, bit_stb_o, frame_stb_o});
    endfunction

    initial begin
        repeat (150000) @(posedge clk_ref);
        mismatched++;
        $display("FAIL R11 watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_ref);
        check("R1 outputs in reset", outs(), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_ref);
        check("R1 outputs idle", outs(), 0);

        // R2 start
        set_cfg(5, 2, 0);
        en = 1'b1;
        @(negedge clk_ref);
        check("R2 first run cycle", outs(), 4'b1011);

        // R11, R6 shortest slot
        measure_frame("R11 5/2/0", 2*16*2*5, 32);

        // R9 mid-frame change
        wait_frame();
        repeat (10) @(negedge clk_ref);
        set_cfg(5, 3, 1);
        begin
            int n = 10;
            do begin @(negedge clk_ref); n++; end while (!frame_stb_o);
            check("R9 old frame kept", n, 320);
        end
        measure_frame("R6 slot ext 1", 2*17*3*5, 34);
        measure_bit("R3 odd divisor", 10, 15);

        // R4 clamp prescale
        set_cfg(0, 3, 0);
        measure_frame("R4 prescale 0", 2*16*3*5, 32);
        measure_bit("R4 prescale 0", 10, 15);

        // R5 clamp bit divisor
        set_cfg(7, 0, 0);
        measure_frame("R5 bitdiv 0", 2*16*2*7, 32);
        measure_bit("R5 bitdiv 0", 7, 14);

        // R11 longest slot
        set_cfg(13, 4, 15);
        measure_frame("R11 13/4/15", 3224, 62);
        measure_bit("R3 even divisor", 26, 52);

        // R10 stop mid-frame
        repeat (77) @(negedge clk_ref);
        en = 1'b0;
        @(negedge clk_ref);
        check("R10 stop outputs", outs(), 0);
        set_cfg(6, 2, 2);
        repeat (20) @(negedge clk_ref);
        check("R10 stay idle", outs(), 0);
        en = 1'b1;
        @(negedge clk_ref);
        check("R10 restart", outs(), 4'b1011);
        measure_frame("R10 after restart", 2*18*2*6, 36);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule